// File: doc/BRIEF.md
# USB Event Interrupt Aggregator

This block gathers the event pulses of a USB on-the-go core and presents them to a processor as one level interrupt. Each transmit endpoint, each receive endpoint and each core-level condition owns one bit of a 32-bit pending-event register. A separate enable register selects which pending bits may reach the processor. Software changes both registers only through write-one-to-set and write-one-to-clear aliases. Software can also inject any event itself, for example to force a VBUS-drive change so that its own handler runs.

The interrupt line is gated by an arm flag. When the line asserts, the flag drops. After the line falls, it cannot rise again until software writes the end-of-interrupt register. An event that arrives while the flag is down stays pending and is delivered on the cycle after the next end-of-interrupt write. The processor reaches every register through a plain 32-bit word-addressed bus. Writes take effect on the next clock edge. Reads are combinational and have no side effects.

Top module: `irq_aggregator`

## Requirements
- R1: The register map is: 0x00 identity (reads the non-zero constant `REV_ID`, default 32'h0A65_0102), 0x04 control, 0x08 status, 0x20 pending, 0x24 pending-set, 0x28 pending-clear, 0x2C enable, 0x30 enable-set, 0x34 enable-clear, 0x38 enabled-pending, 0x3C end-of-interrupt. Any other offset, and every set, clear and end-of-interrupt alias, reads zero.
- R2: Pending bit layout: transmit endpoints 0..4 map to bits 0..4. Receive endpoints 1..4 map to bits 9..12, and bit 8 always reads 0. Core events 0..8 map to bits 16..24, with bit 24 being the VBUS-drive change. Every other bit always reads 0.
- R3: A write to pending-set sets each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R4: A write to pending-clear clears each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R5: When a hardware event pulse and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Enable-set and enable-clear set and clear enable bits. The enable register holds only the bits defined in R2. Writes to offsets 0x00, 0x08, 0x20, 0x2C, 0x38 and to unmapped offsets change nothing.
- R7: Enabled-pending reads the bitwise AND of pending and enable.
- R8: When the block is armed, the interrupt output rises one clock edge after enabled-pending becomes non-zero.
- R9: After the interrupt output has risen, it does not rise again until a write of any value to end-of-interrupt. That write re-arms the block, and if enabled-pending is non-zero the output rises one edge later.
- R10: Writing control with bit 0 set clears pending and enable on the next edge. Control reads zero.
- R11: Status bit 0 reflects the interrupt output and status bit 1 the arm flag. All other status bits read 0.
- R12: After reset, pending and enable are zero, the output is low and the block is armed (status reads 32'h2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt | input | 5 | Transmit endpoint event pulses, endpoints 0..4 |
| rx_evt | input | 4 | Receive endpoint event pulses, endpoints 1..4 |
| core_evt | input | 9 | Core-level event pulses; index 8 is the VBUS-drive change |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
Two of the block's functions can fall in the same clock cycle: a pending-clear write from software and a hardware event pulse on the same bit. The bench provokes this by driving a pending-clear write for bits 3 and 4 in the same cycle as a transmit pulse on endpoint 3. It then reads pending and expects bit 3 set and bit 4 clear. The bench also checks the arm gate. A new event that arrives after the line falls must leave the output low for several cycles. The output may rise only on the edge after the end-of-interrupt write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_IDENT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_PSET    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PCLR    = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ENA     = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_ESET    = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_ECLR    = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ENPEND  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_EOI     = 8'h3C;

    // one-cycle write strobes decoded from the bus
    typedef struct packed {
        logic pend_set;
        logic pend_clr;
        logic ena_set;
        logic ena_clr;
        logic eoi;
        logic soft_rst;
    } wr_strobe_t;

    // contiguous run of ones of length n starting at bit lsb
    function automatic logic [DATA_W-1:0] field_mask(int unsigned lsb, int unsigned n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            if (i >= lsb && i < lsb + n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
    import irq_agg_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_ID = 32'h0A65_0102
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] pend_q,
    input  logic [DATA_W-1:0] ena_q,
    input  logic              irq_q,
    input  logic              armed_q,
    output wr_strobe_t        strb,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] enpend;
    assign enpend = pend_q & ena_q;

    always_comb begin
        strb          = '0;
        strb.pend_set = bus_we && (bus_addr == OFS_PSET);
        strb.pend_clr = bus_we && (bus_addr == OFS_PCLR);
        strb.ena_set  = bus_we && (bus_addr == OFS_ESET);
        strb.ena_clr  = bus_we && (bus_addr == OFS_ECLR);
        strb.eoi      = bus_we && (bus_addr == OFS_EOI);
        strb.soft_rst = bus_we && (bus_addr == OFS_CTRL) && bus_wdata[0];
    end

    always_comb begin
        case (bus_addr)
            OFS_IDENT:  rdata = REV_ID;
            OFS_STATUS: rdata = {{(DATA_W-2){1'b0}}, armed_q, irq_q};
            OFS_PEND:   rdata = pend_q;
            OFS_ENA:    rdata = ena_q;
            OFS_ENPEND: rdata = enpend;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend
    import irq_agg_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        strb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt_vec,
    output logic [DATA_W-1:0] pend_q
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        logic [DATA_W-1:0] set_m, clr_m;
        set_m = strb.pend_set ? wdata : '0;
        clr_m = strb.pend_clr ? wdata : '0;
        st_d  = st_q;
        if (strb.soft_rst) begin
            st_d.pend = '0;
        end else begin
            // hardware events are OR-ed in after the clear so none is lost
            st_d.pend = (((st_q.pend | set_m) & ~clr_m) | evt_vec) & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

endmodule

// File: rtl/irq_agg_ena.sv
module irq_agg_ena
    import irq_agg_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        strb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ena_q
);

    typedef struct packed {
        logic [DATA_W-1:0] ena;
    } ena_state_t;

    ena_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb.soft_rst) begin
            st_d.ena = '0;
        end else if (strb.ena_set) begin
            st_d.ena = (st_q.ena | wdata) & VALID;
        end else if (strb.ena_clr) begin
            st_d.ena = st_q.ena & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_q = st_q.ena;

endmodule

// File: rtl/irq_agg_arm.sv
module irq_agg_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic any_enpend,
    input  logic eoi,
    output logic irq_q,
    output logic armed_q
);

    typedef struct packed {
        logic irq;
        logic armed;
    } arm_state_t;

    localparam arm_state_t ARM_RESET = '{irq: 1'b0, armed: 1'b1};

    arm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // the line may start only when armed and may hold while already high
        st_d.irq = any_enpend && (st_q.armed || st_q.irq);
        if (eoi)
            st_d.armed = 1'b1;
        else if (st_q.armed && any_enpend)
            st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARM_RESET;
        else        st_q <= st_d;
    end

    assign irq_q   = st_q.irq;
    assign armed_q = st_q.armed;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned       NUM_TX   = 5,
    parameter int unsigned       NUM_RX   = 4,
    parameter int unsigned       RX_BASE  = 8,
    parameter int unsigned       NUM_CORE = 9,
    parameter int unsigned       CORE_LSB = 16,
    parameter logic [DATA_W-1:0] REV_ID   = 32'h0A65_0102
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TX-1:0]   tx_evt,
    input  logic [NUM_RX-1:0]   rx_evt,
    input  logic [NUM_CORE-1:0] core_evt,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_o
);

    // receive endpoint numbering starts at 1; slot RX_BASE belongs to endpoint 0
    localparam int unsigned RX_LSB = RX_BASE + 1;
    localparam logic [DATA_W-1:0] VALID =
        field_mask(0, NUM_TX) | field_mask(RX_LSB, NUM_RX) | field_mask(CORE_LSB, NUM_CORE);

    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] ena_q;
    logic              irq_q;
    logic              armed_q;
    wr_strobe_t        strb;

    always_comb begin
        evt_vec = '0;
        for (int unsigned t = 0; t < NUM_TX; t++)   evt_vec[t]            = tx_evt[t];
        for (int unsigned r = 0; r < NUM_RX; r++)   evt_vec[RX_LSB + r]   = rx_evt[r];
        for (int unsigned c = 0; c < NUM_CORE; c++) evt_vec[CORE_LSB + c] = core_evt[c];
    end

    irq_agg_regif #(.REV_ID(REV_ID)) u_regif (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .ena_q     (ena_q),
        .irq_q     (irq_q),
        .armed_q   (armed_q),
        .strb      (strb),
        .rdata     (bus_rdata)
    );

    irq_agg_pend #(.VALID(VALID)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .wdata   (bus_wdata),
        .evt_vec (evt_vec),
        .pend_q  (pend_q)
    );

    irq_agg_ena #(.VALID(VALID)) u_ena (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .wdata  (bus_wdata),
        .ena_q  (ena_q)
    );

    irq_agg_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_enpend (|(pend_q & ena_q)),
        .eoi        (strb.eoi),
        .irq_q      (irq_q),
        .armed_q    (armed_q)
    );

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] evt_vec,
    input logic [DATA_W-1:0] pend_q,
    input logic [DATA_W-1:0] ena_q,
    input logic              irq_o
);

    logic hit_set, hit_clr, hit_soft, hit_eoi;
    assign hit_set  = bus_we && bus_addr == OFS_PSET;
    assign hit_clr  = bus_we && bus_addr == OFS_PCLR;
    assign hit_soft = bus_we && bus_addr == OFS_CTRL && bus_wdata[0];
    assign hit_eoi  = bus_we && bus_addr == OFS_EOI;

    // set by reset or end-of-interrupt, cleared while the line is high
    logic rearm_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rearm_seen_q <= 1'b1;
        else if (hit_eoi) rearm_seen_q <= 1'b1;
        else if (irq_o)   rearm_seen_q <= 1'b0;
    end

    p_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~VALID) == '0);

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((pend_q & $past(bus_wdata) & VALID) == ($past(bus_wdata) & VALID)));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((pend_q & $past(bus_wdata) & ~$past(evt_vec)) == '0));

    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_soft |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(pend_q & ena_q)));

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> rearm_seen_q);

    p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_soft |=> (pend_q == '0 && ena_q == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(.VALID(VALID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_vec   (evt_vec),
    .pend_q    (pend_q),
    .ena_q     (ena_q),
    .irq_o     (irq_o)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/100ps
module irq_aggregator_tb;
    import irq_agg_pkg::*;

    localparam logic [31:0] REV   = 32'h0A65_0102;
    localparam logic [31:0] VALID = 32'h01FF_1E1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tx_evt = '0;
    logic [3:0]  rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #2 clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // monitor: pops each expected item and compares with the port it names
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] act;
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, act, it.exp);
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string r);
        sb_item_t it;
        bus_addr = a;
        #1;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.req = r;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic expect_irq(input logic e, input string r);
        sb_item_t it;
        it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'b0, e}; it.req = r;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
        @(negedge clk);
        tx_evt = t; rx_evt = r; core_evt = c;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; core_evt = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        expect_rd(OFS_IDENT,  REV,   "R1 identity");
        expect_rd(OFS_PEND,   32'h0, "R12 pending");
        expect_rd(OFS_ENA,    32'h0, "R12 enable");
        expect_rd(OFS_STATUS, 32'h2, "R12 status armed");
        expect_irq(1'b0, "R12 irq low");

        // bit layout
        pulse(5'b00100, 4'b0000, 9'h000);
        expect_rd(OFS_PEND, 32'h0000_0004, "R2 tx ep2");
        pulse(5'b00000, 4'b0001, 9'h100);
        expect_rd(OFS_PEND, 32'h0100_0204, "R2 rx ep1 and vbus-drive");
        expect_irq(1'b0, "R8 disabled stays low");

        // enable and interrupt timing
        wr(OFS_ESET, 32'hFFFF_FFFF);
        expect_rd(OFS_ENA, VALID, "R6 enable-set limited");
        expect_rd(OFS_ENPEND, 32'h0100_0204, "R7 and");
        expect_irq(1'b0, "R8 not yet");
        idle(1);
        expect_irq(1'b1, "R8 rise");
        expect_rd(OFS_STATUS, 32'h1, "R11 status");

        wr(OFS_PCLR, 32'hFFFF_FFFF);
        expect_rd(OFS_PEND, 32'h0, "R4 clear all");
        idle(1);
        expect_irq(1'b0, "R8 fall");

        // held off until end-of-interrupt
        pulse(5'b00001, 4'b0000, 9'h000);
        expect_rd(OFS_PEND, 32'h1, "R2 tx ep0");
        idle(2);
        expect_irq(1'b0, "R9 not re-armed");
        wr(OFS_EOI, 32'h0);
        expect_irq(1'b0, "R9 one edge after eoi");
        idle(1);
        expect_irq(1'b1, "R9 rise after eoi");

        // set with zero bits, then event versus clear in one cycle
        wr(OFS_PSET, 32'h0000_0018);
        expect_rd(OFS_PEND, 32'h0000_0019, "R3 set keeps others");
        @(negedge clk);
        bus_we = 1'b1; bus_addr = OFS_PCLR; bus_wdata = 32'h18; tx_evt = 5'b01000;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; tx_evt = '0;
        expect_rd(OFS_PEND, 32'h0000_0009, "R5 event beats clear");

        wr(OFS_ECLR, 32'h0000_001F);
        expect_rd(OFS_ENA, 32'h01FF_1E00, "R6 enable-clear");
        expect_rd(OFS_ENPEND, 32'h0, "R7 and after clear");

        // ignored writes and unmapped reads
        wr(OFS_ENA, 32'h0);
        expect_rd(OFS_ENA, 32'h01FF_1E00, "R6 direct enable write ignored");
        wr(OFS_PEND, 32'h0);
        expect_rd(OFS_PEND, 32'h0000_0009, "R6 direct pending write ignored");
        wr(OFS_IDENT, 32'h0);
        expect_rd(OFS_IDENT, REV, "R6 identity write ignored");
        wr(8'h44, 32'hFFFF_FFFF);
        expect_rd(8'h44, 32'h0, "R1 unmapped reads zero");
        expect_rd(OFS_PSET, 32'h0, "R1 alias reads zero");

        wr(OFS_PSET, 32'hFFFF_FFFF);
        expect_rd(OFS_PEND, VALID, "R2 unused bits stay zero");

        // soft reset
        wr(OFS_CTRL, 32'h1);
        expect_rd(OFS_PEND, 32'h0, "R10 pending cleared");
        expect_rd(OFS_ENA,  32'h0, "R10 enable cleared");
        expect_rd(OFS_CTRL, 32'h0, "R10 control reads zero");

        idle(2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule